// File: doc/BRIEF.md
# Serial Voltage-ID Command Receiver

This block is a two-wire serial slave that accepts voltage-ID commands from a host processor. The host uses a write-only send-byte transfer. The slave samples the serial clock line and the open-drain data line with the system clock, after two-flop synchronizers. It recognises start and stop conditions and shifts in an address byte, which holds a 7-bit address and a direction bit. It then receives one command byte and drives an acknowledge after each byte by pulling the data line low.

The address carries a fixed three-bit prefix and a three-bit mask that selects the target rails. The command byte carries an active-low power-saving flag and a 7-bit voltage code. The received values are held back until the stop condition arrives. Only then are they written into every selected rail register, together with the power-saving flag, and a one-cycle update strobe marks the change. A transfer that is cut off by a repeated start or an early stop leaves every output as it was. The rail registers reset to a boot code set by a parameter.

Top module: `svid_rx`

## Requirements
- R1: While `rst` is high, and until the first committed transfer, every rail slice holds `BOOT_VID`. During the same period `psi_n_o` is 1, and `update_o` and `svd_oe_o` are 0.
- R2: A start condition is the data line falling while the clock line is high. A stop condition is the data line rising while the clock line is high. Bits are sampled on the rising clock edge, most significant bit first.
- R3: An address byte is accepted when all of these hold: address bits 6:4 equal binary 110, at least one of address bits 2:0 is set, and the direction bit (the eighth bit) is 0. The slave acknowledges an accepted address by asserting `svd_oe_o` during the ninth clock-high period.
- R4: Address bit 3 has no effect on whether the address is accepted.
- R5: An address that is not accepted gets no acknowledge. The slave also gives no acknowledge for the command byte that follows, and the transfer changes no output.
- R6: After an accepted address, the command byte is always acknowledged in its ninth clock-high period.
- R7: Address bit k selects rail slice `rail_vid_o[7k+6:7k]`. Bit 0 is the auxiliary rail, bit 1 is rail 0 and bit 2 is rail 1. The command applies to every selected rail, and slices that are not selected keep their value.
- R8: Command bit 7 is written to `psi_n_o`, where 0 allows power saving. Command bits 6:0 are the voltage code written to the selected rails.
- R9: Rail values and `psi_n_o` do not change until the stop condition that ends a complete transfer. They are written two clock cycles after the stop is seen on the synchronized lines.
- R10: A repeated start, or a stop that arrives before the command acknowledge, discards the transfer and changes no output. The repeated start begins a new address byte.
- R11: `update_o` is high for exactly one cycle for each committed transfer. It is high in the same cycle the new values first appear, and rails and `psi_n_o` never change while it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| svc_i | input | 1 | Serial clock line from host |
| svd_i | input | 1 | Serial data line as seen on the wired bus |
| svd_oe_o | output | 1 | When 1, the slave pulls the data line low (acknowledge) |
| rail_vid_o | output | 21 | Three 7-bit rail codes; slice k is selected by address bit k |
| psi_n_o | output | 1 | Active-low power-saving flag from the last commit |
| update_o | output | 1 | One-cycle strobe when new rail values are committed |

## Verification
The bound checker watches four things on every cycle. It checks the reset values and that the update strobe never lasts longer than one cycle. It checks that rails and the power-saving flag only move in a cycle where the strobe is high. It checks that no commit ever coincides with an active acknowledge. Address decoding, acknowledge timing within the ninth clock, rail masking, bit order and the discarding of aborted transfers can only be shown by the bench's scenarios. Those scenarios drive whole bus transfers and compare the committed values with values the bench works out on its own.

// File: rtl/svid_pkg.sv
package svid_pkg;
  localparam int ADDR_W   = 7;
  localparam int SEL_W    = 3;
  localparam int VID_W    = 7;
  localparam int BYTE_W   = 8;
  localparam int CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [2:0] ADDR_PREFIX = 3'b110;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DATA,
    PH_HOLD,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/svid_sync.sv
module svid_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic svc_i,
  input  logic svd_i,
  output logic svd_s_o,
  output logic svc_rise_o,
  output logic svc_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] svc_q;
  logic [STAGES-1:0] svd_q;
  logic              svc_d;
  logic              svd_d;
  logic              svc_s;
  logic              svd_s;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          svc_q <= '1;
          svd_q <= '1;
        end else begin
          svc_q <= svc_i;
          svd_q <= svd_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          svc_q <= '1;
          svd_q <= '1;
        end else begin
          svc_q <= {svc_q[STAGES-2:0], svc_i};
          svd_q <= {svd_q[STAGES-2:0], svd_i};
        end
      end
    end
  endgenerate

  assign svc_s = svc_q[STAGES-1];
  assign svd_s = svd_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      svc_d <= 1'b1;
      svd_d <= 1'b1;
    end else begin
      svc_d <= svc_s;
      svd_d <= svd_s;
    end
  end

  assign svd_s_o    = svd_s;
  assign svc_rise_o = svc_s & ~svc_d;
  assign svc_fall_o = ~svc_s & svc_d;
  assign start_o    = svc_s & svc_d & svd_d & ~svd_s;
  assign stop_o     = svc_s & svc_d & ~svd_d & svd_s;
endmodule

// File: rtl/svid_frame.sv
module svid_frame
  import svid_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                svd_s_i,
  input  logic                svc_rise_i,
  input  logic                svc_fall_i,
  input  logic                start_i,
  input  logic                stop_i,
  output logic                svd_oe_o,
  output logic                cmt_o,
  output logic [SEL_W-1:0]    cmt_sel_o,
  output logic [BYTE_W-1:0]   cmt_byte_o
);
  phase_e              phase;
  logic [CNT_W-1:0]    bit_cnt;
  logic [BYTE_W-1:0]   shreg;
  logic [SEL_W-1:0]    sel_q;
  logic [BYTE_W-1:0]   data_q;
  logic                oe_q;
  logic                cmt_q;
  logic                addr_ok;
  logic                last_bit;
  logic                in_byte;

  // shreg[7:1] is the address, shreg[0] the direction bit
  assign addr_ok  = (shreg[BYTE_W-1 -: 3] == ADDR_PREFIX) &&
                    (shreg[SEL_W:1] != '0) && !shreg[0];
  assign last_bit = (bit_cnt == CNT_W'(BYTE_W));
  assign in_byte  = (phase == PH_ADDR) || (phase == PH_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      sel_q   <= '0;
      data_q  <= '0;
      oe_q    <= 1'b0;
      cmt_q   <= 1'b0;
    end else begin
      cmt_q <= 1'b0;
      if (start_i) begin
        phase   <= PH_ADDR;
        bit_cnt <= '0;
        oe_q    <= 1'b0;
      end else if (stop_i) begin
        cmt_q   <= (phase == PH_HOLD);
        phase   <= PH_IDLE;
        bit_cnt <= '0;
        oe_q    <= 1'b0;
      end else begin
        if (svc_fall_i) begin
          oe_q <= last_bit &&
                  (((phase == PH_ADDR) && addr_ok) || (phase == PH_DATA));
        end
        if (svc_rise_i && in_byte) begin
          if (last_bit) begin
            bit_cnt <= '0;
            if (phase == PH_ADDR) begin
              if (addr_ok) begin
                phase <= PH_DATA;
                sel_q <= shreg[SEL_W:1];
              end else begin
                phase <= PH_SKIP;
              end
            end else begin
              phase  <= PH_HOLD;
              data_q <= shreg;
            end
          end else begin
            shreg   <= {shreg[BYTE_W-2:0], svd_s_i};
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end

  assign svd_oe_o   = oe_q;
  assign cmt_o      = cmt_q;
  assign cmt_sel_o  = sel_q;
  assign cmt_byte_o = data_q;
endmodule

// File: rtl/svid_rail_bank.sv
module svid_rail_bank
  import svid_pkg::*;
#(
  parameter logic [VID_W-1:0] BOOT_VID = 7'h30
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmt_i,
  input  logic [SEL_W-1:0]         sel_i,
  input  logic [BYTE_W-1:0]        byte_i,
  output logic [SEL_W*VID_W-1:0]   rail_vid_o,
  output logic                     psi_n_o,
  output logic                     update_o
);
  generate
    for (genvar r = 0; r < SEL_W; r++) begin : g_rail
      logic [VID_W-1:0] vid_q;
      always_ff @(posedge clk) begin
        if (rst)                    vid_q <= BOOT_VID;
        else if (cmt_i && sel_i[r]) vid_q <= byte_i[VID_W-1:0];
      end
      assign rail_vid_o[r*VID_W +: VID_W] = vid_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      psi_n_o  <= 1'b1;
      update_o <= 1'b0;
    end else begin
      update_o <= cmt_i;
      if (cmt_i) psi_n_o <= byte_i[VID_W];
    end
  end
endmodule

// File: rtl/svid_rx.sv
module svid_rx
  import svid_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [VID_W-1:0]  BOOT_VID    = 7'h30
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     svc_i,
  input  logic                     svd_i,
  output logic                     svd_oe_o,
  output logic [SEL_W*VID_W-1:0]   rail_vid_o,
  output logic                     psi_n_o,
  output logic                     update_o
);
  logic              svd_s;
  logic              svc_rise;
  logic              svc_fall;
  logic              start_c;
  logic              stop_c;
  logic              cmt;
  logic [SEL_W-1:0]  cmt_sel;
  logic [BYTE_W-1:0] cmt_byte;

  svid_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .svc_i      (svc_i),
    .svd_i      (svd_i),
    .svd_s_o    (svd_s),
    .svc_rise_o (svc_rise),
    .svc_fall_o (svc_fall),
    .start_o    (start_c),
    .stop_o     (stop_c)
  );

  svid_frame u_frame (
    .clk        (clk),
    .rst        (rst),
    .svd_s_i    (svd_s),
    .svc_rise_i (svc_rise),
    .svc_fall_i (svc_fall),
    .start_i    (start_c),
    .stop_i     (stop_c),
    .svd_oe_o   (svd_oe_o),
    .cmt_o      (cmt),
    .cmt_sel_o  (cmt_sel),
    .cmt_byte_o (cmt_byte)
  );

  svid_rail_bank #(.BOOT_VID(BOOT_VID)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .cmt_i      (cmt),
    .sel_i      (cmt_sel),
    .byte_i     (cmt_byte),
    .rail_vid_o (rail_vid_o),
    .psi_n_o    (psi_n_o),
    .update_o   (update_o)
  );
endmodule

// File: rtl/svid_rx_chk.sv
module svid_rx_chk
  import svid_pkg::*;
#(
  parameter logic [VID_W-1:0] BOOT_VID = 7'h30
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   svd_oe_o,
  input logic [SEL_W*VID_W-1:0] rail_vid_o,
  input logic                   psi_n_o,
  input logic                   update_o
);
  // R1: one cycle after reset is sampled, outputs show their reset values
  p_reset_vals_r1: assert property (@(posedge clk)
    rst |=> (psi_n_o && !update_o && !svd_oe_o &&
             rail_vid_o == {SEL_W{BOOT_VID}}));

  // R11: strobe lasts a single cycle
  p_strobe_single_r11: assert property (@(posedge clk) disable iff (rst)
    update_o |=> !update_o);

  // R9, R11: outputs move only with the strobe
  p_rails_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !update_o |-> ($stable(rail_vid_o) && $stable(psi_n_o)));

  // R6: a commit follows a stop, so the acknowledge is already released
  p_no_ack_at_commit_r6: assert property (@(posedge clk) disable iff (rst)
    update_o |-> !svd_oe_o);
endmodule

bind svid_rx svid_rx_chk #(.BOOT_VID(BOOT_VID)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .svd_oe_o   (svd_oe_o),
  .rail_vid_o (rail_vid_o),
  .psi_n_o    (psi_n_o),
  .update_o   (update_o)
);

// File: tb/svid_rx_test.sv
`timescale 1ns/1ps
module svid_rx_test;
  localparam int H = 8;
  localparam logic [6:0] BOOT = 7'h30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic svc = 1'b1;
  logic host_low = 1'b0;
  logic svd_oe;
  logic [20:0] rail;
  logic psi_n;
  logic upd;
  logic svd_line;

  int checks = 0;
  int fails = 0;
  int upd_cnt = 0;
  logic [6:0] exp_rail [3];
  logic exp_psi;

  assign svd_line = !(host_low || svd_oe);

  always #2.5 clk = ~clk;

  svid_rx #(.SYNC_STAGES(2), .BOOT_VID(BOOT)) uut (
    .clk(clk), .rst(rst), .svc_i(svc), .svd_i(svd_line),
    .svd_oe_o(svd_oe), .rail_vid_o(rail), .psi_n_o(psi_n), .update_o(upd)
  );

  always @(negedge clk) if (!rst && upd) upd_cnt++;

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_rails(input string tag);
    for (int r = 0; r < 3; r++)
      chk(rail[r*7 +: 7] == exp_rail[r], tag, rail[r*7 +: 7], exp_rail[r]);
    chk(psi_n == exp_psi, tag, psi_n, exp_psi);
  endtask

  task automatic bus_start();
    if (svc == 1'b0) begin
      wt(2); host_low = 1'b0; wt(H - 2); svc = 1'b1; wt(H);
    end
    host_low = 1'b1; wt(H); svc = 1'b0;
  endtask

  task automatic bus_stop();
    wt(2); host_low = 1'b1; wt(H - 2); svc = 1'b1; wt(H);
    host_low = 1'b0; wt(H);
  endtask

  task automatic send_bit(input bit b);
    wt(2); host_low = !b; wt(H - 2); svc = 1'b1; wt(H); svc = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    wt(2); host_low = 1'b0; wt(H - 2); svc = 1'b1;
    wt(H / 2); acked = svd_oe; wt(H / 2); svc = 1'b0;
  endtask

  task automatic txn(input logic [6:0] addr, input bit rw, input logic [7:0] data,
                     input bit do_stop, output bit a1, output bit a2);
    bus_start();
    send_byte({addr, rw}, a1);
    send_byte(data, a2);
    if (do_stop) bus_stop();
    wt(8);
  endtask

  task automatic t_reset();
    chk_rails("R1 reset rails/psi");
    chk(upd == 1'b0, "R1 update idle", upd, 0);
    chk(svd_oe == 1'b0, "R1 no ack at reset", svd_oe, 0);
  endtask

  task automatic t_single();
    bit a1, a2; int u0;
    u0 = upd_cnt;
    txn(7'b110_0_100, 1'b0, 8'h2A, 1'b0, a1, a2);
    chk(a1, "R3 address ack", a1, 1);
    chk(a2, "R6 data ack", a2, 1);
    chk_rails("R9 no change before stop");
    chk(upd_cnt == u0, "R9 no strobe before stop", upd_cnt - u0, 0);
    bus_stop(); wt(8);
    exp_rail[2] = 7'h2A; exp_psi = 1'b0;
    chk_rails("R2 R7 R8 single rail commit");
    chk(upd_cnt == u0 + 1, "R11 one strobe", upd_cnt - u0, 1);
  endtask

  task automatic t_multi();
    bit a1, a2; int u0;
    u0 = upd_cnt;
    txn(7'b110_1_011, 1'b0, 8'h95, 1'b1, a1, a2);
    chk(a1, "R4 reserved bit set still acked", a1, 1);
    exp_rail[0] = 7'h15; exp_rail[1] = 7'h15; exp_psi = 1'b1;
    chk_rails("R7 R8 multi rail commit");
    chk(upd_cnt == u0 + 1, "R11 one strobe multi", upd_cnt - u0, 1);
  endtask

  task automatic t_reject(input logic [6:0] addr, input bit rw, input string tag);
    bit a1, a2; int u0;
    u0 = upd_cnt;
    txn(addr, rw, 8'h01, 1'b1, a1, a2);
    chk(!a1, {tag, " addr nack"}, a1, 0);
    chk(!a2, {tag, " data nack"}, a2, 0);
    chk_rails({tag, " rails kept"});
    chk(upd_cnt == u0, {tag, " no strobe"}, upd_cnt - u0, 0);
  endtask

  task automatic t_abort();
    bit a1, a2; int u0;
    u0 = upd_cnt;
    txn(7'b110_0_111, 1'b0, 8'h7F, 1'b0, a1, a2);
    bus_start(); bus_stop(); wt(8);
    chk_rails("R10 repeated start then stop discards");
    chk(upd_cnt == u0, "R10 no strobe after abort", upd_cnt - u0, 0);
    txn(7'b110_0_001, 1'b0, 8'h11, 1'b0, a1, a2);
    txn(7'b110_0_010, 1'b0, 8'h22, 1'b1, a1, a2);
    chk(a1, "R10 repeated start new address acked", a1, 1);
    exp_rail[1] = 7'h22; exp_psi = 1'b0;
    chk_rails("R10 only second transfer committed");
    chk(upd_cnt == u0 + 1, "R10 one strobe", upd_cnt - u0, 1);
  endtask

  task automatic t_stop_mid();
    bit a1; int u0;
    u0 = upd_cnt;
    bus_start();
    send_byte({7'b110_0_111, 1'b0}, a1);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop(); wt(8);
    chk_rails("R10 early stop discards");
    chk(upd_cnt == u0, "R10 no strobe early stop", upd_cnt - u0, 0);
  endtask

  initial begin
    for (int r = 0; r < 3; r++) exp_rail[r] = BOOT;
    exp_psi = 1'b1;
    wt(5);
    t_reset();
    rst = 1'b0;
    wt(5);
    t_reset();
    t_single();
    t_multi();
    t_reject(7'b101_0_111, 1'b0, "R5 bad prefix");
    t_reject(7'b110_1_000, 1'b0, "R5 R3 empty select");
    t_reject(7'b110_0_111, 1'b1, "R3 read direction");
    t_abort();
    t_stop_mid();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule